// File: doc/BRIEF.md
# Accumulator Stored-Program Processor

This block is a small 32-bit accumulator machine that runs a program kept in its own word-addressed store. The store holds two to the power of `ADDR_BITS` words. The machine has three registers: an accumulator, a control counter and an instruction register. It steps through the program one instruction at a time, using a fixed four-cycle sequence for each: advance the counter, fetch, fetch the operand, execute. The instruction set has eight codes: absolute jump, relative jump, load-negated, store, subtract (two codes), skip-if-negative and stop.

The control counter is a full data word. When a carry reaches bit 13 or above, the machine changes mode. If only bit 13 is set in the counter's opcode field, each fetched word is added to the previous instruction word to form the new instruction. If a higher bit is set, the machine stops with a fatal indication.

A host loads a program and reads results through a simple port. That port is only usable while the machine is halted. A start pulse clears the accumulator and the counter and runs from word 1.

Top module: `acc_machine`

## Requirements
- R1: After reset, `halted` is 1 and `fatal` is 0.
- R2: A high `start` while halted clears the accumulator, the control counter and the instruction register, and clears `fatal`. `halted` falls one cycle later. The first fetch comes from word 1.
- R3: The opcode is instruction bits 15..13. The codes are 0 jump, 1 relative jump, 2 load-negated, 3 store, 4 and 5 subtract, 6 skip-if-negative, 7 stop. The operand address is the low `ADDR_BITS` bits of the instruction. Every store address, including each fetch address taken from the counter, wraps modulo the store size.
- R4: Jump loads the counter with the operand word, so execution continues at that value plus one. Relative jump adds the operand word to the counter.
- R5: Load-negated puts the 32-bit two's-complement negation of the operand word in the accumulator. Subtract takes the operand word from the accumulator with wraparound. Store writes the accumulator to the operand location.
- R6: Skip-if-negative adds one extra count to the counter when accumulator bit 31 is 1. Otherwise it does nothing.
- R7: Stop raises `halted` at the end of its execute cycle. `halted` stays high until the next `start`.
- R8: Before each increment, the machine tests counter bits 15..13. If they are 000, the fetched word becomes the instruction. If they are 001, the instruction becomes the previous instruction plus the fetched word.
- R9: Any other value of counter bits 15..13 at that test raises `fatal` and `halted` in the same cycle, without an increment. `fatal` stays set until the next `start`.
- R10: While halted, `host_we` writes `host_wdata` to `host_addr`, and `host_rdata` returns the word at `host_addr` one cycle later. While running, `host_we` has no effect on the store.
- R11: Each instruction takes exactly four cycles, so `halted` stays low for at least four cycles after a start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a run from word 1 (sampled while halted) |
| halted | output | 1 | Machine is stopped |
| fatal | output | 1 | Last run ended on a counter overflow into opcode bits |
| host_we | input | 1 | Host write strobe (halted only) |
| host_addr | input | ADDR_BITS | Host word address |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Store word read one cycle after `host_addr` |

## Verification
The most delicate coincidence is a counter increment that carries into bit 13 while the fetch address wraps back to word 0. A jump to 0x1FFE provokes it. The increment that wraps also arms instruction addition for the following fetch, so the first summed instruction is formed from word 1 combined with the word executed from word 0. The bench drives these runs, along with a relative-jump run that reaches the fatal field. It compares `halted` and `fatal` against a behavioural model on every clock. After each halt it reads back the words that only a correctly summed instruction would have written.

// File: rtl/acc_machine_pkg.sv
package acc_machine_pkg;
  localparam int OPC_LSB = 13;
  localparam int OPC_W   = 3;

  typedef enum logic [2:0] {
    OP_JUMP = 3'd0,
    OP_RJMP = 3'd1,
    OP_LNEG = 3'd2,
    OP_STOR = 3'd3,
    OP_SUBA = 3'd4,
    OP_SUBB = 3'd5,
    OP_SKPN = 3'd6,
    OP_HALT = 3'd7
  } opc_t;

  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_STEP = 3'd1,
    PH_LOAD = 3'd2,
    PH_OPND = 3'd3,
    PH_EXEC = 3'd4
  } phase_t;

  typedef enum logic [1:0] {
    CK_PLAIN = 2'd0,
    CK_SUM   = 2'd1,
    CK_DEAD  = 2'd2
  } ctl_chk_t;
endpackage

// File: rtl/acc_store.sv
module acc_store #(
  parameter int ADDR_BITS = 5,
  parameter int WORD_W    = 32
) (
  input  logic                 clk,
  input  logic                 we,
  input  logic [ADDR_BITS-1:0] addr,
  input  logic [WORD_W-1:0]    wdata,
  output logic [WORD_W-1:0]    rdata
);
  localparam int DEPTH = 1 << ADDR_BITS;

  logic [WORD_W-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      cells[addr] <= wdata;
    end
    rdata <= cells[addr];
  end
endmodule

// File: rtl/acc_seq.sv
module acc_seq
  import acc_machine_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     start,
  input  ctl_chk_t chk,
  input  opc_t     opc,
  output phase_t   phase,
  output logic     fatal
);
  phase_t phase_d;
  logic   fatal_d;

  always_comb begin
    phase_d = phase;
    fatal_d = fatal;
    unique case (phase)
      PH_IDLE: begin
        if (start) begin
          phase_d = PH_STEP;
          fatal_d = 1'b0;
        end
      end
      PH_STEP: begin
        if (chk == CK_DEAD) begin
          phase_d = PH_IDLE;
          fatal_d = 1'b1;
        end else begin
          phase_d = PH_LOAD;
        end
      end
      PH_LOAD: phase_d = PH_OPND;
      PH_OPND: phase_d = PH_EXEC;
      PH_EXEC: phase_d = (opc == OP_HALT) ? PH_IDLE : PH_STEP;
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      fatal <= 1'b0;
    end else begin
      phase <= phase_d;
      fatal <= fatal_d;
    end
  end
endmodule

// File: rtl/acc_dpath.sv
module acc_dpath
  import acc_machine_pkg::*;
#(
  parameter int ADDR_BITS = 5,
  parameter int WORD_W    = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  phase_t               phase,
  input  logic [WORD_W-1:0]    rdata,
  output logic [ADDR_BITS-1:0] mem_addr,
  output logic                 mem_we,
  output logic [WORD_W-1:0]    mem_wdata,
  output ctl_chk_t             chk,
  output opc_t                 opc
);
  localparam int SIGN = WORD_W - 1;

  logic [WORD_W-1:0] acc_q, acc_d;
  logic [WORD_W-1:0] ctl_q, ctl_d;
  logic [WORD_W-1:0] ins_q, ins_d;
  logic              sum_q, sum_d;
  logic              reg_en;
  logic [WORD_W-1:0] ctl_inc;
  logic [OPC_W-1:0]  ctl_field;

  assign ctl_inc   = ctl_q + 1'b1;
  assign ctl_field = ctl_q[OPC_LSB +: OPC_W];
  assign opc       = opc_t'(ins_q[OPC_LSB +: OPC_W]);

  always_comb begin
    if (ctl_field == '0) begin
      chk = CK_PLAIN;
    end else if (ctl_field == OPC_W'(1)) begin
      chk = CK_SUM;
    end else begin
      chk = CK_DEAD;
    end
  end

  assign mem_addr  = (phase == PH_STEP) ? ctl_inc[ADDR_BITS-1:0] : ins_q[ADDR_BITS-1:0];
  assign mem_we    = (phase == PH_EXEC) && (opc == OP_STOR);
  assign mem_wdata = acc_q;
  assign reg_en    = (phase != PH_IDLE) || start;

  always_comb begin
    acc_d = acc_q;
    ctl_d = ctl_q;
    ins_d = ins_q;
    sum_d = sum_q;
    unique case (phase)
      PH_IDLE: begin
        if (start) begin
          acc_d = '0;
          ctl_d = '0;
          ins_d = '0;
          sum_d = 1'b0;
        end
      end
      PH_STEP: begin
        if (chk != CK_DEAD) begin
          sum_d = (chk == CK_SUM);
          ctl_d = ctl_inc;
        end
      end
      PH_LOAD: begin
        ins_d = sum_q ? (ins_q + rdata) : rdata;
      end
      PH_EXEC: begin
        unique case (opc)
          OP_JUMP: ctl_d = rdata;
          OP_RJMP: ctl_d = ctl_q + rdata;
          OP_LNEG: acc_d = '0 - rdata;
          OP_SUBA,
          OP_SUBB: acc_d = acc_q - rdata;
          OP_SKPN: begin
            if (acc_q[SIGN]) begin
              ctl_d = ctl_inc;
            end
          end
          default: ;
        endcase
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      ctl_q <= '0;
      ins_q <= '0;
      sum_q <= 1'b0;
    end else if (reg_en) begin
      acc_q <= acc_d;
      ctl_q <= ctl_d;
      ins_q <= ins_d;
      sum_q <= sum_d;
    end
  end
endmodule

// File: rtl/acc_machine.sv
module acc_machine
  import acc_machine_pkg::*;
#(
  parameter int ADDR_BITS = 5,
  parameter int WORD_W    = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  output logic                 halted,
  output logic                 fatal,
  input  logic                 host_we,
  input  logic [ADDR_BITS-1:0] host_addr,
  input  logic [WORD_W-1:0]    host_wdata,
  output logic [WORD_W-1:0]    host_rdata
);
  localparam int SYNC_STAGES = 2;

  logic [SYNC_STAGES-1:0] rst_pipe;
  logic                   core_rst_n;
  phase_t                 phase;
  ctl_chk_t               chk;
  opc_t                   opc;
  logic [ADDR_BITS-1:0]   core_addr, st_addr;
  logic                   core_we, st_we;
  logic [WORD_W-1:0]      core_wdata, st_wdata, st_rdata;
  logic                   idle;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= '0;
    end else begin
      rst_pipe <= {rst_pipe[SYNC_STAGES-2:0], 1'b1};
    end
  end
  assign core_rst_n = rst_pipe[SYNC_STAGES-1];

  acc_seq u_seq (
    .clk   (clk),
    .rst_n (core_rst_n),
    .start (start),
    .chk   (chk),
    .opc   (opc),
    .phase (phase),
    .fatal (fatal)
  );

  acc_dpath #(.ADDR_BITS(ADDR_BITS), .WORD_W(WORD_W)) u_dpath (
    .clk       (clk),
    .rst_n     (core_rst_n),
    .start     (start),
    .phase     (phase),
    .rdata     (st_rdata),
    .mem_addr  (core_addr),
    .mem_we    (core_we),
    .mem_wdata (core_wdata),
    .chk       (chk),
    .opc       (opc)
  );

  assign idle     = (phase == PH_IDLE);
  assign st_addr  = idle ? host_addr  : core_addr;
  assign st_we    = idle ? host_we    : core_we;
  assign st_wdata = idle ? host_wdata : core_wdata;

  acc_store #(.ADDR_BITS(ADDR_BITS), .WORD_W(WORD_W)) u_store (
    .clk   (clk),
    .we    (st_we),
    .addr  (st_addr),
    .wdata (st_wdata),
    .rdata (st_rdata)
  );

  assign halted     = idle;
  assign host_rdata = st_rdata;
endmodule

// File: rtl/acc_machine_chk.sv
module acc_machine_chk (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic halted,
  input logic fatal
);
  assert_fatal_is_halted_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fatal |-> halted);

  assert_fatal_with_halt_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fatal) |-> $rose(halted));

  assert_halt_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (halted && !start) |=> (halted && $stable(fatal)));

  assert_start_runs_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (halted && start) |=> (!halted && !fatal));

  assert_min_run_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(halted) |=> !halted ##1 !halted ##1 !halted);
endmodule

bind acc_machine acc_machine_chk u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .start  (start),
  .halted (halted),
  .fatal  (fatal)
);

// File: tb/test_acc_machine.sv
`timescale 1ns/1ps
module test_acc_machine;
  localparam int AB = 5;
  localparam int NW = 1 << AB;

  logic          clk = 1'b0;
  logic          rst_n, start, host_we;
  logic [AB-1:0] host_addr;
  logic [31:0]   host_wdata, host_rdata;
  logic          halted, fatal;

  always #4 clk = ~clk;

  acc_machine #(.ADDR_BITS(AB), .WORD_W(32)) i_acc_machine (
    .clk(clk), .rst_n(rst_n), .start(start), .halted(halted), .fatal(fatal),
    .host_we(host_we), .host_addr(host_addr), .host_wdata(host_wdata),
    .host_rdata(host_rdata)
  );

  int    n_cmp = 0;
  int    n_bad = 0;
  bit    cmp_on = 0;
  bit    done = 0;
  string req = "R1";

  // behavioural reference
  logic [31:0] m_mem [NW];
  logic [31:0] m_acc, m_ci, m_pi;
  bit          m_sum, m_fatal;
  int          m_phase;

  function automatic logic [31:0] ins(int op, int a);
    return 32'((op << 13) | a);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_phase = 0;
      m_fatal = 0;
    end else begin
      automatic bit          was_idle = (m_phase == 0);
      automatic int          fld;
      automatic logic [31:0] w;
      case (m_phase)
        0: if (start) begin
             m_acc = 0; m_ci = 0; m_pi = 0; m_sum = 0; m_fatal = 0; m_phase = 1;
           end
        1: begin
             fld = int'(m_ci[15:13]);
             if (fld > 1) begin m_fatal = 1; m_phase = 0; end
             else begin m_sum = (fld == 1); m_ci = m_ci + 1; m_phase = 2; end
           end
        2: begin
             w = m_mem[m_ci[AB-1:0]];
             m_pi = m_sum ? m_pi + w : w;
             m_phase = 3;
           end
        3: m_phase = 4;
        default: begin
             w = m_mem[m_pi[AB-1:0]];
             m_phase = 1;
             case (int'(m_pi[15:13]))
               0: m_ci = w;
               1: m_ci = m_ci + w;
               2: m_acc = -w;
               3: m_mem[m_pi[AB-1:0]] = m_acc;
               4, 5: m_acc = m_acc - w;
               6: if (m_acc[31]) m_ci = m_ci + 1;
               default: m_phase = 0;
             endcase
           end
      endcase
      if (was_idle && host_we) m_mem[host_addr] = host_wdata;
    end
  end

  // per-cycle comparison (R11 timing, R7/R9 flags)
  always @(negedge clk) begin
    if (cmp_on && !done) begin
      n_cmp++;
      if (halted !== (m_phase == 0) || fatal !== m_fatal) begin
        n_bad++;
        $display("FAIL %s/R11 cycle: halted=%0b fatal=%0b expected halted=%0b fatal=%0b",
                 req, halted, fatal, (m_phase == 0), m_fatal);
      end
    end
  end

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic poke(int a, logic [31:0] d);
    @(negedge clk);
    host_we = 1; host_addr = AB'(a); host_wdata = d;
    @(negedge clk);
    host_we = 0;
  endtask

  task automatic peek(int a, logic [31:0] exp, string tag);
    @(negedge clk);
    host_addr = AB'(a);
    @(negedge clk);
    check(tag, host_rdata, exp);
    check({tag, " model"}, host_rdata, m_mem[a]);
  endtask

  task automatic clear_mem();
    for (int i = 0; i < NW; i++) poke(i, 32'h0);
  endtask

  task automatic go(string tag, bit poke_while_running);
    int t;
    req = tag;
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    if (poke_while_running) begin
      repeat (6) @(negedge clk);
      host_we = 1; host_addr = AB'(23); host_wdata = 32'h55;   // R10 ignored write
      @(negedge clk); host_we = 0;
    end
    t = 0;
    while (!(halted && m_phase == 0) && t < 40000) begin
      @(negedge clk); t++;
    end
    if (t >= 40000) begin
      n_bad++;
      $display("FAIL %s: run did not halt, actual=running expected=halted", tag);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 0; start = 0; host_we = 0; host_addr = '0; host_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    check("R1 halted", {31'b0, halted}, 32'd1);
    check("R1 fatal", {31'b0, fatal}, 32'd0);
    cmp_on = 1;

    // program A: R3 R4 R5 R6 R10
    clear_mem();
    poke(1, ins(2, 20)); poke(2, ins(4, 21)); poke(3, ins(3, 22));
    poke(4, ins(6, 0));  poke(5, ins(3, 23)); poke(6, ins(2, 22));
    poke(7, ins(6, 0));  poke(8, ins(3, 24)); poke(9, ins(1, 25));
    poke(10, ins(3, 26)); poke(11, ins(3, 26)); poke(12, ins(0, 27));
    poke(13, ins(3, 26)); poke(14, ins(5, 26)); poke(15, ins(7, 0));
    poke(20, 32'd5); poke(21, 32'd3); poke(25, 32'd2); poke(27, 32'd14);
    go("R2 R4 R5 R6", 1);
    peek(22, 32'hFFFF_FFF8, "R5 negate+subtract+store");
    peek(23, 32'h0, "R6 skip taken / R10 write ignored while running");
    peek(24, 32'd8, "R6 no skip on positive");
    peek(26, 32'h0, "R4 jumps bypass stores");
    peek(14, ins(5, 26), "R10 host readback");

    // program B: carry into bit 13 with address wrap, summed instructions
    clear_mem();
    poke(1, ins(0, 10)); poke(10, 32'h1FFE);
    poke(31, ins(2, 11)); poke(11, 32'd7);
    poke(0, ins(3, 12));
    poke(2, 32'h2000); poke(3, 32'h6000);
    go("R8 R3", 0);
    check("R8 no fatal", {31'b0, fatal}, 32'd0);
    peek(12, 32'hFFFF_FFF9, "R3 wrap fetch of word 31 and 0");
    peek(22, 32'hFFFF_FFF9, "R8 summed store instruction");

    // program C: fatal field
    clear_mem();
    poke(1, ins(0, 10)); poke(10, 32'h3FFE); poke(31, 32'h2000);
    go("R9", 0);
    check("R9 fatal set", {31'b0, fatal}, 32'd1);
    check("R9 halted", {31'b0, halted}, 32'd1);
    repeat (4) @(negedge clk);
    check("R9 fatal sticky", {31'b0, fatal}, 32'd1);

    // program D: restart clears fatal, immediate stop
    poke(1, ins(7, 0));
    go("R2 R7", 0);
    check("R2 fatal cleared", {31'b0, fatal}, 32'd0);
    check("R7 halted after stop", {31'b0, halted}, 32'd1);

    repeat (4) @(negedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule